// File: doc/BRIEF.md
# Triggered Burst Sequencer with Markers

This block steps a waveform generator through a fixed playback program that loops forever. In each pass it sits idle until a rising edge arrives on the trigger input. It then plays 32 segment pairs and returns to idle. Each pair is a sine segment followed by a DC segment at zero level. Both segment lengths are supplied at run time. They are captured once per pass, when the trigger edge is detected.

During playback the block drives three things: a sample address into each of two internal constant ROMs (one holds a sine-shaped table, the other holds zeros), a segment-select flag, and the sample read from the selected ROM. Two marker outputs rise together at the first sample of every sine segment and stay high for 100 samples. One marker is meant to trigger a capture instrument and the other goes to a monitor pin.

The latency from the trigger to the first sample is fixed, so a downstream capture device sees the same delay on every pass. A status bit shows when the block is blocked on the trigger. A one-cycle pulse and a pass counter report each completed pass.

The controller is a state machine with five states:
- `ST_WAIT`: idle, blocked on the trigger.
- `ST_ARM`: a single fixed-latency cycle.
- `ST_SINE`: playing a sine segment.
- `ST_DC`: playing a DC segment.
- `ST_FINISH`: a single cycle that fires the done pulse.

Its transitions are:
- **start**: `ST_WAIT`→`ST_ARM`, taken on a detected edge while enabled.
- **launch**: `ST_ARM`→`ST_SINE`.
- **to_dc**: `ST_SINE`→`ST_DC`, taken on the last sine sample.
- **next_pair**: `ST_DC`→`ST_SINE`, taken on the last DC sample of pairs 1 to 31.
- **wrap**: `ST_DC`→`ST_FINISH`, taken on the last DC sample of pair 32.
- **rearm**: `ST_FINISH`→`ST_WAIT`.
- **abort**: any state→`ST_WAIT`, taken whenever enable is low.

Top module: `burst_sequencer`

## Requirements
- R1: After reset with `enable` high: `waiting`=1, `active`=0, both markers 0, `done`=0, `sample`=0 and `pass_count`=0.
- R2: `trig_in` passes through a two-stage synchronizer. If `trig_in` is first high at rising clock edge k while the block waits, then `waiting` falls after edge k+2, and after edge k+3 the output shows the first sine sample: `active`=1, `seg_dc`=0, `sine_addr`=0.
- R3: A pass consists of exactly 32 pairs. Each pair is one sine segment of the captured sine length followed by one DC segment of the captured DC length, with one sample per cycle. Within each segment the address counts up from 0 and wraps modulo 64.
- R4: During a DC segment, `seg_dc`=1, `dc_addr` follows the sample index and `sample`=0. When `active`=0, `sample`=0.
- R5: `mark_cap` and `mark_mon` are identical. Both are high exactly for sine-segment sample indexes 0 to 99 and low at all other times.
- R6: The sine table holds two's-complement samples. Address 0 gives 0 and address 16 gives +2047, the positive peak.
- R7: Both lengths are captured at the detected trigger edge and held for the whole pass. Any length below 101 is played as 101.
- R8: The cycle after the last DC sample of pair 32 shows `done`=1 with `active`=0. The next cycle shows `done`=0, `waiting`=1 and `pass_count` increased by one.
- R9: Trigger edges that arrive while a pass plays are ignored. No extra pass starts after the running one ends.
- R10: While `enable` is low, `waiting`=0 and trigger edges start nothing. Dropping `enable` mid-pass returns the block to idle on the next cycle with `active`=0, with no `done` pulse and no change to `pass_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Permits starts; low aborts any pass |
| trig_in | input | 1 | Asynchronous script trigger, rising edge |
| sine_len | input | 12 | Sine segment length in samples |
| dc_len | input | 12 | DC segment length in samples |
| sine_addr | output | 6 | Address into the sine ROM |
| dc_addr | output | 6 | Address into the DC ROM |
| seg_dc | output | 1 | 1 = DC segment selected, 0 = sine |
| active | output | 1 | A sample is being played this cycle |
| sample | output | 12 | Selected ROM sample, two's complement |
| mark_cap | output | 1 | Marker toward the capture device |
| mark_mon | output | 1 | Marker toward the monitor pin |
| waiting | output | 1 | Blocked on the trigger |
| done | output | 1 | One-cycle pulse at the end of a pass |
| pass_count | output | 16 | Number of completed passes, wrapping |

## Verification
The assertions assume that `trig_in` is stable for at least two cycles around each change. They also assume that segment lengths at or above 101 fit in 12 bits. The stimulus keeps every trigger pulse several cycles wide and draws lengths from 101 to 180, apart from one directed case that deliberately drives short lengths to reach the clamp. Enable is changed only at chosen points, so each abort lands inside a known segment.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_ARM,
        ST_SINE,
        ST_DC,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/wave_rom.sv
module wave_rom #(
    parameter int AW    = 6,
    parameter int DW    = 12,
    parameter bit FLAT  = 1'b0
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;
    localparam int AMP   = (1 << (DW - 1)) - 1;

    function automatic logic [DEPTH*DW-1:0] build_table();
        logic [DEPTH*DW-1:0] t;
        int x;
        int mag;
        int v;
        t = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (FLAT) begin
                v = 0;
            end else begin
                x   = i % HALF;
                mag = (4 * AMP * x * (HALF - x)) / (HALF * HALF);
                v   = (i < HALF) ? mag : -mag;
            end
            t[i*DW +: DW] = v[DW-1:0];
        end
        return t;
    endfunction

    localparam logic [DEPTH*DW-1:0] TABLE = build_table();

    assign data = TABLE[addr*DW +: DW];
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
    import burst_seq_pkg::*;
#(
    parameter int LEN_W    = 12,
    parameter int ROM_AW   = 6,
    parameter int DW       = 12,
    parameter int PAIRS    = 32,
    parameter int MARK_LEN = 100,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              trig_in,
    input  logic [LEN_W-1:0]  sine_len,
    input  logic [LEN_W-1:0]  dc_len,
    output logic [ROM_AW-1:0] sine_addr,
    output logic [ROM_AW-1:0] dc_addr,
    output logic              seg_dc,
    output logic              active,
    output logic [DW-1:0]     sample,
    output logic              mark_cap,
    output logic              mark_mon,
    output logic              waiting,
    output logic              done,
    output logic [CNT_W-1:0]  pass_count
);
    localparam int PAIR_W  = $clog2(PAIRS + 1);
    localparam int MIN_LEN = MARK_LEN + 1;

    seq_state_t       state;
    logic [LEN_W-1:0] idx;
    logic [PAIR_W-1:0] pair;
    logic [LEN_W-1:0] sine_len_q;
    logic [LEN_W-1:0] dc_len_q;
    logic             trig_rise;
    logic [DW-1:0]    sine_word;
    logic [DW-1:0]    dc_word;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        return (l < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : l;
    endfunction

    trig_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .rise     (trig_rise)
    );

    wave_rom #(.AW(ROM_AW), .DW(DW), .FLAT(1'b0)) u_sine_rom (
        .addr (sine_addr),
        .data (sine_word)
    );

    wave_rom #(.AW(ROM_AW), .DW(DW), .FLAT(1'b1)) u_dc_rom (
        .addr (dc_addr),
        .data (dc_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_WAIT;
            idx        <= '0;
            pair       <= '0;
            sine_len_q <= LEN_W'(MIN_LEN);
            dc_len_q   <= LEN_W'(MIN_LEN);
            pass_count <= '0;
        end else if (!enable) begin
            state <= ST_WAIT;
            idx   <= '0;
            pair  <= '0;
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (trig_rise) begin
                        state      <= ST_ARM;
                        sine_len_q <= clamp_len(sine_len);
                        dc_len_q   <= clamp_len(dc_len);
                    end
                end
                ST_ARM: begin
                    state <= ST_SINE;
                    idx   <= '0;
                    pair  <= '0;
                end
                ST_SINE: begin
                    if (idx == sine_len_q - 1'b1) begin
                        state <= ST_DC;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_DC: begin
                    if (idx == dc_len_q - 1'b1) begin
                        idx <= '0;
                        if (pair == PAIR_W'(PAIRS - 1)) begin
                            state <= ST_FINISH;
                        end else begin
                            state <= ST_SINE;
                            pair  <= pair + 1'b1;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_FINISH: begin
                    state      <= ST_WAIT;
                    pass_count <= pass_count + 1'b1;
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    always_comb begin
        sine_addr = '0;
        dc_addr   = '0;
        seg_dc    = 1'b0;
        active    = 1'b0;
        mark_cap  = 1'b0;
        waiting   = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_WAIT:   waiting = enable;
            ST_ARM:    ;
            ST_SINE: begin
                active    = 1'b1;
                sine_addr = idx[ROM_AW-1:0];
                mark_cap  = (idx < LEN_W'(MARK_LEN));
            end
            ST_DC: begin
                active  = 1'b1;
                seg_dc  = 1'b1;
                dc_addr = idx[ROM_AW-1:0];
            end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
        mark_mon = mark_cap;
        sample   = !active ? '0 : (seg_dc ? dc_word : sine_word);
    end
endmodule

// File: rtl/burst_sequencer_checker.sv
module burst_sequencer_checker #(
    parameter int ROM_AW = 6,
    parameter int DW     = 12,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [ROM_AW-1:0] sine_addr,
    input logic              seg_dc,
    input logic              active,
    input logic [DW-1:0]     sample,
    input logic              mark_cap,
    input logic              mark_mon,
    input logic              waiting,
    input logic              done,
    input logic [CNT_W-1:0]  pass_count
);
    a_r1_idle_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> (!active && !done));

    a_r2_launch_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (!seg_dc && sine_addr == '0 && mark_cap));

    a_r4_dc_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (active && seg_dc) |-> (sample == '0));

    a_r5_markers_equal: assert property (@(posedge clk) disable iff (!rst_n)
        mark_cap == mark_mon);

    a_r5_marker_in_sine: assert property (@(posedge clk) disable iff (!rst_n)
        mark_cap |-> (active && !seg_dc));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enable) |=> (pass_count == $past(pass_count) + 1'b1));

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!active && !done && !waiting) || enable);
endmodule

bind burst_sequencer burst_sequencer_checker #(
    .ROM_AW (ROM_AW),
    .DW     (DW),
    .CNT_W  (CNT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sine_addr  (sine_addr),
    .seg_dc     (seg_dc),
    .active     (active),
    .sample     (sample),
    .mark_cap   (mark_cap),
    .mark_mon   (mark_mon),
    .waiting    (waiting),
    .done       (done),
    .pass_count (pass_count)
);

// File: tb/burst_sequencer_test.sv
module burst_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        trig_in;
    logic [11:0] sine_len;
    logic [11:0] dc_len;
    logic [5:0]  sine_addr;
    logic [5:0]  dc_addr;
    logic        seg_dc;
    logic        active;
    logic [11:0] sample;
    logic        mark_cap;
    logic        mark_mon;
    logic        waiting;
    logic        done;
    logic [15:0] pass_count;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;
    int exp_count = 0;

    always #2 clk = ~clk;

    burst_sequencer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig_in(trig_in),
        .sine_len(sine_len), .dc_len(dc_len), .sine_addr(sine_addr),
        .dc_addr(dc_addr), .seg_dc(seg_dc), .active(active), .sample(sample),
        .mark_cap(mark_cap), .mark_mon(mark_mon), .waiting(waiting),
        .done(done), .pass_count(pass_count)
    );

    function automatic int eff_len(input int l);
        return (l < 101) ? 101 : l;
    endfunction

    function automatic logic [11:0] exp_sine(input int a);
        if (a == 0)  return 12'd0;
        if (a == 16) return 12'd2047;
        return 12'hxxx;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Trigger and follow the launch latency (R2); lengths captured at detection (R7).
    task automatic launch(input int sl, input int dl, input int new_sl, input int new_dl);
        sine_len = 12'(sl);
        dc_len   = 12'(dl);
        trig_in  = 1'b1;
        step();
        chk(waiting == 1'b1, "R2", "waiting after edge k", waiting, 1);
        step();
        chk(waiting == 1'b1, "R2", "waiting after edge k+1", waiting, 1);
        step();
        chk(waiting == 1'b0 && active == 1'b0, "R2", "armed after edge k+2",
            {waiting, active}, 2'b00);
        sine_len = 12'(new_sl);
        dc_len   = 12'(new_dl);
        trig_in  = 1'b0;
        step();
    endtask

    // Walk a full pass cycle by cycle (R3, R4, R5, R6, R8, R9).
    task automatic play_pass(input int sl, input int dl, input bit noise);
        int es = eff_len(sl);
        int ed = eff_len(dl);
        for (int p = 0; p < 32; p++) begin
            for (int i = 0; i < es; i++) begin
                bit mk = (i < 100);
                if (noise && p == 3 && i == 0) trig_in = 1'b1;
                if (noise && p == 3 && i == 6) trig_in = 1'b0;
                chk(active && !seg_dc && sine_addr == 6'(i % 64) && !waiting,
                    "R3", "sine sample", {active, seg_dc, sine_addr},
                    {1'b1, 1'b0, 6'(i % 64)});
                chk(mark_cap == mk && mark_mon == mk, "R5", "markers in sine",
                    {mark_cap, mark_mon}, {mk, mk});
                if (i % 64 == 0 || i % 64 == 16)
                    chk(sample == exp_sine(i % 64), "R6", "sine table",
                        sample, exp_sine(i % 64));
                step();
            end
            for (int j = 0; j < ed; j++) begin
                chk(active && seg_dc && dc_addr == 6'(j % 64) && sample == 12'd0,
                    "R4", "dc sample", {active, seg_dc, dc_addr, sample},
                    {1'b1, 1'b1, 6'(j % 64), 12'd0});
                chk(!mark_cap && !mark_mon, "R5", "markers in dc",
                    {mark_cap, mark_mon}, 0);
                step();
            end
        end
        chk(done && !active && !waiting, "R8", "done pulse",
            {done, active, waiting}, 3'b100);
        step();
        exp_count++;
        chk(!done && waiting && pass_count == 16'(exp_count), "R8", "rearm and count",
            {done, waiting, pass_count}, {1'b0, 1'b1, 16'(exp_count)});
        if (noise) begin
            for (int k = 0; k < 10; k++) step();
            chk(waiting && !active, "R9", "no extra pass", {waiting, active}, 2'b10);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; enable = 1'b1; trig_in = 1'b0;
        sine_len = 12'd120; dc_len = 12'd120;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(waiting && !active && !mark_cap && !mark_mon && !done &&
            sample == 0 && pass_count == 0, "R1", "reset state",
            {waiting, active, mark_cap, mark_mon, done, sample, pass_count},
            {1'b1, 4'b0, 12'd0, 16'd0});

        // Directed: basic pass with trigger noise during playback (R9).
        launch(130, 110, 130, 110);
        play_pass(130, 110, 1'b1);

        // Directed: short lengths clamp, and a mid-pass change is not taken (R7).
        repeat (4) step();
        launch(20, 0, 300, 300);
        play_pass(20, 0, 1'b0);

        // Random passes.
        for (int r = 0; r < 3; r++) begin
            int sl = 101 + int'($urandom_range(79));
            int dl = 101 + int'($urandom_range(79));
            repeat (2 + int'($urandom_range(6))) step();
            launch(sl, dl, int'($urandom_range(4095)), int'($urandom_range(4095)));
            play_pass(sl, dl, r[0]);
        end

        // Enable low blocks starts (R10).
        enable = 1'b0;
        step();
        chk(!waiting && !active, "R10", "disabled idle", {waiting, active}, 2'b00);
        trig_in = 1'b1;
        repeat (4) step();
        trig_in = 1'b0;
        repeat (6) step();
        chk(!active && !waiting, "R10", "trigger ignored when disabled",
            {active, waiting}, 2'b00);
        enable = 1'b1;
        repeat (5) step();
        chk(waiting && !active, "R10", "no start after enable", {waiting, active}, 2'b10);

        // Abort mid-pass (R10).
        launch(150, 150, 150, 150);
        for (int i = 0; i < 40; i++) step();
        enable = 1'b0;
        step();
        chk(!active && !done && !mark_cap, "R10", "abort to idle",
            {active, done, mark_cap}, 3'b000);
        enable = 1'b1;
        step();
        chk(waiting && pass_count == 16'(exp_count), "R10", "abort keeps count",
            {waiting, pass_count}, {1'b1, 16'(exp_count)});

        // Clean restart after abort (R2, R3).
        repeat (3) step();
        launch(101, 101, 101, 101);
        play_pass(101, 101, 1'b0);

        finish_run();
    end
endmodule